// File: doc/BRIEF.md
# Elapsed Time Counter Core

This block keeps a 44-bit running total of how long a chosen condition has been true. Its clock is the 32.768 kHz timebase. An internal divide-by-8 prescaler produces a 4096 Hz tick, so one count stands for 244 µs. A control byte selects what gates the count: the part running from its primary supply, the part running from its battery, or an external event input whose active level is programmable. When the power-fail flag is raised, counting is blocked in every mode and the event input is disregarded.

The live counter has a second copy behind it, and that copy is what the system reads. While the transfer bit in the control byte is set, the readable copy reloads from the live counter on every tick. While the bit is clear, the copy is frozen, so a byte-by-byte read stays coherent. Software can preload the live counter one byte at a time. The preloaded value reaches the readable copy on the first tick after the transfer bit is set again. The upper 32 bits of the live counter are also brought out directly, for alarm comparison by a neighbouring block.

Top module: `etc_core`

## Requirements
- R1: Reset clears the live counter and the readable copy to zero, sets the source selection to off (code 0), sets the event polarity to active high, and sets the transfer bit.
- R2: The tick fires once in every 8 clock cycles. On each tick where the enable condition holds, the live counter increases by exactly one, and it holds between ticks.
- R3: Source code 1 (control bits [1:0]) counts only while `on_battery` is 0. Source code 2 counts only while `on_battery` is 1.
- R4: Source code 3 counts while the synchronised event input equals the polarity bit (control bit 2; 1 means active high).
- R5: While `pwr_fail` is 1, the counter does not advance in any source mode.
- R6: While the transfer bit (control bit 3) is 1, the readable copy equals the live counter after every tick. While it is 0, the readable copy holds its value.
- R7: A write to address k (0 to 5) replaces byte k of the live counter, least significant byte at address 0, with only the low 4 bits used at address 5. Address 6 is the control byte. A preloaded value appears on `rd_count` at the first tick after the transfer bit is 1.
- R8: The live counter wraps from all ones to zero.
- R9: `live_hi` always shows bits [43:12] of the live counter.
- R10: Source code 0 never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase |
| rst_n | input | 1 | Active-low asynchronous reset |
| on_battery | input | 1 | 1 when the battery supplies the part |
| pwr_fail | input | 1 | 1 while the part is in power fail |
| ext_in | input | 1 | Asynchronous external event input |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 3 | Write address: 0 to 5 counter bytes, 6 control |
| wr_data | input | 8 | Write data byte |
| rd_count | output | 44 | Readable snapshot of the count |
| live_hi | output | 32 | Upper 32 bits of the live counter |

## Verification
Each source mode is run with its enable condition true and then false. A design with a swapped supply decode or an inverted polarity bit would count in the wrong half of these cases. Power fail is applied in both supply and event modes, so a design that only blocks one of the paths would still advance. With the transfer bit clear, the readable copy is watched while the live counter is preloaded; a copy that leaked the new value early would break coherent reads. The all-ones preload must roll over to zero at the next tick, which catches saturation or a carry lost into the top nibble.

// File: rtl/etc_pkg.sv
package etc_pkg;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_PRI = 2'd1,
        SRC_BAT = 2'd2,
        SRC_EXT = 2'd3
    } src_mode_e;

    typedef struct packed {
        logic      xfer_en;
        logic      evt_high;
        src_mode_e mode;
    } etc_ctrl_t;

    localparam etc_ctrl_t CTRL_RESET = '{xfer_en: 1'b1, evt_high: 1'b1, mode: SRC_OFF};

endpackage

// File: rtl/etc_prescaler.sv
module etc_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        tick    = (phase_q == PW'(DIV - 1));
        phase_d = tick ? '0 : phase_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/etc_enable_sel.sv
module etc_enable_sel
    import etc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  src_mode_e mode,
    input  logic      evt_high,
    input  logic      on_battery,
    input  logic      pwr_fail,
    input  logic      ext_in,
    output logic      count_en
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   evt_level;

    always_comb begin
        sync_d    = {sync_q[SYNC_STAGES-2:0], ext_in};
        evt_level = sync_q[SYNC_STAGES-1];
        unique case (mode)
            SRC_PRI: count_en = !on_battery;
            SRC_BAT: count_en = on_battery;
            SRC_EXT: count_en = (evt_level == evt_high);
            default: count_en = 1'b0;
        endcase
        if (pwr_fail) count_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end
endmodule

// File: rtl/etc_core.sv
module etc_core
    import etc_pkg::*;
#(
    parameter int CNT_W  = 44,
    parameter int HI_W   = 32,
    parameter int DIV    = 8,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on_battery,
    input  logic              pwr_fail,
    input  logic              ext_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  rd_count,
    output logic [HI_W-1:0]   live_hi
);
    localparam int NBYTES = (CNT_W + BYTE_W - 1) / BYTE_W;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NBYTES);

    typedef struct packed {
        logic [CNT_W-1:0] live;
        logic [CNT_W-1:0] snap;
        etc_ctrl_t        ctrl;
    } etc_state_t;

    etc_state_t st_d, st_q;
    logic       tick_w;
    logic       en_w;

    etc_prescaler #(.DIV(DIV)) i_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_w)
    );

    etc_enable_sel #(.SYNC_STAGES(2)) i_ensel (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (st_q.ctrl.mode),
        .evt_high  (st_q.ctrl.evt_high),
        .on_battery(on_battery),
        .pwr_fail  (pwr_fail),
        .ext_in    (ext_in),
        .count_en  (en_w)
    );

    always_comb begin
        st_d = st_q;
        if (tick_w && en_w) st_d.live = st_q.live + CNT_W'(1);
        if (wr_en) begin
            if (wr_addr == CTRL_ADDR) begin
                st_d.ctrl.mode     = src_mode_e'(wr_data[1:0]);
                st_d.ctrl.evt_high = wr_data[2];
                st_d.ctrl.xfer_en  = wr_data[3];
            end else begin
                for (int i = 0; i < CNT_W; i++) begin
                    if (wr_addr == ADDR_W'(i / BYTE_W)) st_d.live[i] = wr_data[i % BYTE_W];
                end
            end
        end
        if (tick_w && st_q.ctrl.xfer_en) st_d.snap = st_d.live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{live: '0, snap: '0, ctrl: CTRL_RESET};
        else        st_q <= st_d;
    end

    assign rd_count = st_q.snap;
    assign live_hi  = st_q.live[CNT_W-1 -: HI_W];
endmodule

// File: rtl/etc_core_chk.sv
module etc_core_chk #(
    parameter int CNT_W = 44
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             count_en,
    input logic             xfer_en,
    input logic             wr_en,
    input logic             pwr_fail,
    input logic [CNT_W-1:0] live,
    input logic [CNT_W-1:0] rd_count
);
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_en && !wr_en && (live != '1)) |=> (live == $past(live) + CNT_W'(1)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && count_en) && !wr_en) |=> $stable(live));

    assert_pfail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && !wr_en) |=> $stable(live));

    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> $stable(rd_count));

    assert_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && xfer_en) |=> (rd_count == live));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_en && !wr_en && (live == '1)) |=> (live == '0));
endmodule

bind etc_core etc_core_chk #(.CNT_W(CNT_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .count_en(en_w),
    .xfer_en (st_q.ctrl.xfer_en),
    .wr_en   (wr_en),
    .pwr_fail(pwr_fail),
    .live    (st_q.live),
    .rd_count(rd_count)
);

// File: tb/test_etc_core.sv
module test_etc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        on_battery = 1'b0, pwr_fail = 1'b0, ext_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [43:0] rd_count;
    logic [31:0] live_hi;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    etc_core i_etc_core (
        .clk(clk), .rst_n(rst_n), .on_battery(on_battery), .pwr_fail(pwr_fail),
        .ext_in(ext_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_count(rd_count), .live_hi(live_hi)
    );

    task automatic check(input string tag, input logic [43:0] act, input logic [43:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // settle inputs, then count ticks seen in a 40-cycle window (5 ticks)
    task automatic window(input string tag, input logic [43:0] exp);
        logic [43:0] a;
        cycles(16);
        a = rd_count;
        cycles(40);
        check(tag, rd_count - a, exp);
    endtask

    task automatic t_reset;
        check("R1 rd_count reset", rd_count, '0);
        check("R1 live_hi reset", {12'd0, live_hi}, '0);
        window("R10 default source off", 44'd0);
    endtask

    task automatic t_primary;
        wr(3'd6, 8'h09);
        on_battery = 1'b0; window("R3 primary on primary", 44'd5);
        on_battery = 1'b1; window("R3 primary on battery", 44'd0);
    endtask

    task automatic t_battery;
        wr(3'd6, 8'h0A);
        on_battery = 1'b1; window("R3 battery on battery", 44'd5);
        on_battery = 1'b0; window("R3 battery on primary", 44'd0);
    endtask

    task automatic t_event;
        wr(3'd6, 8'h0F);
        ext_in = 1'b1; window("R4 high-active, input high", 44'd5);
        ext_in = 1'b0; window("R4 high-active, input low", 44'd0);
        wr(3'd6, 8'h0B);
        window("R4 low-active, input low", 44'd5);
        ext_in = 1'b1; window("R4 low-active, input high", 44'd0);
    endtask

    task automatic t_pfail;
        pwr_fail = 1'b1;
        wr(3'd6, 8'h09); on_battery = 1'b0;
        window("R5 power fail, primary mode", 44'd0);
        wr(3'd6, 8'h0B); ext_in = 1'b0;
        window("R5 power fail, event mode", 44'd0);
        pwr_fail = 1'b0;
        window("R5 counting resumes after power fail", 44'd5);
    endtask

    task automatic t_hold;
        logic [43:0] h;
        wr(3'd6, 8'h01); on_battery = 1'b0;
        cycles(2);
        h = rd_count;
        cycles(40);
        check("R6 copy frozen while transfer clear", rd_count, h);
        wr(3'd6, 8'h09);
        window("R6 copy follows again", 44'd5);
    endtask

    task automatic t_load;
        logic [43:0] v = 44'h9AB_CDEF_0123;
        logic [43:0] h;
        wr(3'd6, 8'h00);
        cycles(2);
        h = rd_count;
        for (int b = 0; b < 6; b++) wr(3'(b), v[b*8 +: 8]);
        check("R7 copy unchanged by preload", rd_count, h);
        check("R9 live_hi shows preload", {12'd0, live_hi}, {12'd0, v[43:12]});
        wr(3'd6, 8'h08);
        cycles(8);
        check("R7 preload visible after transfer set", rd_count, v);
    endtask

    task automatic t_wrap;
        wr(3'd6, 8'h08);
        for (int b = 0; b < 5; b++) wr(3'(b), 8'hFF);
        wr(3'd5, 8'h0F);
        cycles(8);
        check("R8 all-ones preload", rd_count, '1);
        on_battery = 1'b0;
        wr(3'd6, 8'h09);
        cycles(8);
        check("R8 wrap to zero", rd_count, '0);
        check("R9 live_hi after wrap", {12'd0, live_hi}, '0);
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_primary();
        t_battery();
        t_event();
        t_pfail();
        t_hold();
        t_load();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule